// File: doc/BRIEF.md
# Four-Channel Bus-Hold DMA Controller

This block moves bytes between I/O devices and memory while the processor stands aside. Four channels each take an active-low request from a device. Software programs each channel once, through a small write port, with a start address, a byte count and a mode. When an eligible channel asks for service, the controller raises a hold request to the processor and waits for hold acknowledge. It then grants the highest-priority requester through that channel's active-low acknowledge. For a normal channel it drives the address and read/write strobes for a fixed number of clocks per byte and updates the address and count. When it is done it gives the bus back.

A channel can be set to cascade mode. In that mode it only relays a downstream controller's request upward as a bus request, and relays the grant downward as its acknowledge. It generates no address and no strobes.

Configuration words are written with `cfg_we`, a channel number, a register select (0 = current address, 1 = remaining count, 2 = mode) and a data word. The mode word bits are:
- bit0: enable
- bit1: direction (0 = I/O to memory, 1 = memory to I/O)
- bit2: single-transfer
- bit3: mask
- bit4: cascade

Top module: `dma_ctrl4`

## Requirements
- R1: A channel is eligible when it is unmasked and either enabled or in cascade. When an eligible channel requests while idle and `hold_ack` is low, `hold_req` rises on the next clock. No acknowledge, address or strobe is driven until `hold_ack` has been sampled high; the grant appears one clock after that.
- R2: Requests and acknowledges are active low. At most one `dack_n` bit is low at any time, and it belongs to the granted channel.
- R3: With several eligible requests at once, channel 0 wins over 1, 1 over 2, and 2 over 3.
- R4: During a transfer `bus_oe` is high and `bus_addr` shows the channel's current address. After each byte the address rises by one and the count falls by one.
- R5: Direction 0 drives `ior_n` and `memw_n` low together; direction 1 drives `memr_n` and `iow_n` low together. Strobes stay low for BEATS clocks per byte and are high whenever no byte is moving.
- R6: A programmed count N yields N+1 bytes. `tc` is high only in the final clock of the last byte, and the channel's enable bit is then cleared, so further requests are ignored.
- R7: In single-transfer mode `hold_req` drops after every byte and the channel re-arbitrates. In block mode the bus is kept while the request stays low and the count has not run out.
- R8: If the request goes away while waiting for `hold_ack`, `hold_req` drops on the next clock and no byte moves.
- R9: A masked channel's request never raises `hold_req`.
- R10: A cascade channel, once granted, holds its `dack_n` low with `bus_oe` low and all strobes high. It keeps the bus while its request stays low; one clock after the request rises, the bus is released.
- R11: Configuration writes are ignored while a channel owns the bus (transfer or cascade).
- R12: After reset, and whenever `hold_req` falls, all acknowledges and strobes are inactive and `bus_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dreq_n | input | NCH | Per-channel device request, active low |
| dack_n | output | NCH | Per-channel acknowledge, active low |
| hold_req | output | 1 | Bus request to the processor |
| hold_ack | input | 1 | Bus grant from the processor |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | log2(NCH) | Channel being written |
| cfg_sel | input | 2 | Register select: 0 address, 1 count, 2 mode |
| cfg_wdata | input | DW | Write data |
| bus_addr | output | AW | Memory address, zero when not driven |
| bus_oe | output | 1 | Address and strobes are being driven |
| ior_n | output | 1 | I/O read strobe, active low |
| iow_n | output | 1 | I/O write strobe, active low |
| memr_n | output | 1 | Memory read strobe, active low |
| memw_n | output | 1 | Memory write strobe, active low |
| tc | output | 1 | Terminal-count pulse |

## Verification
`hold_req` is due one clock after an eligible request is sampled, and it falls one clock after a cancelling request release or after the last clock of a byte. Acknowledge, address and strobes appear one clock after `hold_ack` is sampled high and last BEATS clocks per byte. `tc` coincides with the final clock of the last byte. The bench drives stimulus on the falling edge and samples all outputs on the falling edge that follows the rising edge where each result is due. A falling-edge monitor holds an independent per-channel model of address, count and direction, and checks every bus cycle against it.

// File: rtl/dma4_pkg.sv
package dma4_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ASK  = 2'd1,
    ST_MOVE = 2'd2,
    ST_PASS = 2'd3
  } seq_st_e;

  typedef enum logic [1:0] {
    SEL_ADDR  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_MODE  = 2'd2
  } cfg_sel_e;

  localparam int MODE_W = 5;

  // Field order matches the mode word: bit0 enable ... bit4 cascade.
  typedef struct packed {
    logic cascade;
    logic mask;
    logic single;
    logic mem2io;
    logic enable;
  } ch_mode_t;

endpackage

// File: rtl/dma4_chan.sv
module dma4_chan
  import dma4_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wdata,
  input  logic          step,
  output logic [AW-1:0] cur_addr,
  output ch_mode_t      mode,
  output logic          last_byte
);

  logic [AW-1:0] addr_q, addr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  ch_mode_t      mode_q, mode_d;

  always_comb begin
    addr_d = addr_q;
    cnt_d  = cnt_q;
    mode_d = mode_q;
    if (wr_en) begin
      case (wr_sel)
        SEL_ADDR:  addr_d = wdata[AW-1:0];
        SEL_COUNT: cnt_d  = wdata[CW-1:0];
        SEL_MODE:  mode_d = ch_mode_t'(wdata[MODE_W-1:0]);
        default:   ;
      endcase
    end else if (step) begin
      addr_d = addr_q + 1'b1;
      cnt_d  = cnt_q - 1'b1;
      if (cnt_q == '0) mode_d.enable = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      mode_q <= '0;
    end else begin
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
      mode_q <= mode_d;
    end
  end

  assign cur_addr  = addr_q;
  assign mode      = mode_q;
  assign last_byte = (cnt_q == '0);

  // R6: the byte that empties the count disables the channel
  p_tc_clears_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_en && last_byte) |=> !mode_q.enable);

  // R4: each byte advances the address by one
  p_step_advances_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_en) |=> (addr_q == $past(addr_q) + 1'b1));

endmodule

// File: rtl/dma4_prio.sv
module dma4_prio #(
  parameter  int NCH = 4,
  localparam int IW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] elig,
  output logic [IW-1:0]  win_idx,
  output logic           any_elig
);

  always_comb begin
    win_idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (elig[i]) win_idx = IW'(i);
    end
  end

  assign any_elig = |elig;

endmodule

// File: rtl/dma4_seq.sv
module dma4_seq
  import dma4_pkg::*;
#(
  parameter  int NCH   = 4,
  parameter  int BEATS = 2,
  localparam int IW    = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hold_ack,
  input  logic           any_elig,
  input  logic [IW-1:0]  win_idx,
  input  logic [NCH-1:0] elig,
  input  logic [NCH-1:0] casc,
  input  logic [NCH-1:0] single,
  input  logic [NCH-1:0] last_byte,
  output seq_st_e        st,
  output logic [IW-1:0]  own_idx,
  output logic           beat_last
);

  seq_st_e       st_q, st_d;
  logic [IW-1:0] own_q, own_d;
  logic [BW-1:0] beat_q, beat_d;

  assign beat_last = (st_q == ST_MOVE) && (beat_q == BW'(BEATS - 1));

  always_comb begin
    st_d   = st_q;
    own_d  = own_q;
    beat_d = beat_q;
    case (st_q)
      ST_IDLE: if (any_elig && !hold_ack) st_d = ST_ASK;
      ST_ASK: begin
        if (!any_elig) begin
          st_d = ST_IDLE;
        end else if (hold_ack) begin
          own_d  = win_idx;
          beat_d = '0;
          st_d   = casc[win_idx] ? ST_PASS : ST_MOVE;
        end
      end
      ST_MOVE: begin
        if (beat_last) begin
          beat_d = '0;
          if (last_byte[own_q] || single[own_q] || !elig[own_q]) st_d = ST_IDLE;
        end else begin
          beat_d = beat_q + 1'b1;
        end
      end
      ST_PASS: if (!elig[own_q]) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      own_q  <= '0;
      beat_q <= '0;
    end else begin
      st_q   <= st_d;
      own_q  <= own_d;
      beat_q <= beat_d;
    end
  end

  assign st      = st_q;
  assign own_idx = own_q;

  // R1: ownership begins only after the grant was seen
  p_own_needs_ack_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == ST_MOVE || st_q == ST_PASS) |-> $past(hold_ack));

  // R7: single mode lets the bus go after each byte
  p_single_lets_go_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_last && single[own_q]) |=> (st_q == ST_IDLE));

  // R8: a withdrawn request aborts the wait
  p_cancel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ASK && !any_elig) |=> (st_q == ST_IDLE));

  // R10: cascade ownership lasts while the request stays
  p_cascade_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PASS && elig[own_q]) |=> (st_q == ST_PASS));

endmodule

// File: rtl/dma_ctrl4.sv
module dma_ctrl4
  import dma4_pkg::*;
#(
  parameter  int NCH   = 4,
  parameter  int AW    = 16,
  parameter  int CW    = 16,
  parameter  int DW    = 16,
  parameter  int BEATS = 2,
  localparam int IW    = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] dreq_n,
  output logic [NCH-1:0] dack_n,
  output logic           hold_req,
  input  logic           hold_ack,
  input  logic           cfg_we,
  input  logic [IW-1:0]  cfg_ch,
  input  logic [1:0]     cfg_sel,
  input  logic [DW-1:0]  cfg_wdata,
  output logic [AW-1:0]  bus_addr,
  output logic           bus_oe,
  output logic           ior_n,
  output logic           iow_n,
  output logic           memr_n,
  output logic           memw_n,
  output logic           tc
);

  seq_st_e       st;
  logic [IW-1:0] own_idx;
  logic [IW-1:0] win_idx;
  logic          any_elig;
  logic          beat_last;
  logic          owning;
  logic          moving;
  logic          wr_ok;

  logic [NCH-1:0] elig, casc, single, last_byte, dir;
  logic [AW-1:0]  ch_addr [NCH];
  ch_mode_t       ch_mode [NCH];

  assign owning = (st == ST_MOVE) || (st == ST_PASS);
  assign moving = (st == ST_MOVE);
  assign wr_ok  = cfg_we && !owning;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dma4_chan #(.AW(AW), .CW(CW), .DW(DW)) i_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_ok && (cfg_ch == IW'(g))),
      .wr_sel    (cfg_sel),
      .wdata     (cfg_wdata),
      .step      (beat_last && (own_idx == IW'(g))),
      .cur_addr  (ch_addr[g]),
      .mode      (ch_mode[g]),
      .last_byte (last_byte[g])
    );
    assign casc[g]   = ch_mode[g].cascade;
    assign single[g] = ch_mode[g].single;
    assign dir[g]    = ch_mode[g].mem2io;
    assign elig[g]   = !dreq_n[g] && !ch_mode[g].mask &&
                       (ch_mode[g].enable || ch_mode[g].cascade);
    assign dack_n[g] = !(owning && (own_idx == IW'(g)));
  end

  dma4_prio #(.NCH(NCH)) i_prio (
    .elig     (elig),
    .win_idx  (win_idx),
    .any_elig (any_elig)
  );

  dma4_seq #(.NCH(NCH), .BEATS(BEATS)) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_ack  (hold_ack),
    .any_elig  (any_elig),
    .win_idx   (win_idx),
    .elig      (elig),
    .casc      (casc),
    .single    (single),
    .last_byte (last_byte),
    .st        (st),
    .own_idx   (own_idx),
    .beat_last (beat_last)
  );

  assign hold_req = (st != ST_IDLE);
  assign bus_oe   = moving;
  assign bus_addr = moving ? ch_addr[own_idx] : '0;
  assign ior_n    = !(moving && !dir[own_idx]);
  assign memw_n   = !(moving && !dir[own_idx]);
  assign memr_n   = !(moving && dir[own_idx]);
  assign iow_n    = !(moving && dir[own_idx]);
  assign tc       = beat_last && last_byte[own_idx];

  // R2: never more than one acknowledge
  p_one_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~dack_n));

  // R5: no memory-to-memory or I/O-to-I/O strobe pairing
  p_no_pairing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!memr_n && !memw_n) && !(!ior_n && !iow_n));

  // R12: bus released cleanly when hold falls
  p_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_req) |-> (&dack_n && !bus_oe && ior_n && iow_n && memr_n && memw_n));

endmodule

// File: tb/test_dma_ctrl4.sv
module test_dma_ctrl4;
  localparam int NCH = 4, AW = 16, DW = 16, BEATS = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic [NCH-1:0] dreq_n, dack_n;
  logic hold_req, hold_ack;
  logic cfg_we;
  logic [1:0] cfg_ch, cfg_sel;
  logic [DW-1:0] cfg_wdata;
  logic [AW-1:0] bus_addr;
  logic bus_oe, ior_n, iow_n, memr_n, memw_n, tc;

  always #5 clk = ~clk;

  bit auto_ack, man_ack, ack_echo, mon_on, prev_hr;
  assign hold_ack = auto_ack ? ack_echo : man_ack;

  dma_ctrl4 #(.NCH(NCH), .AW(AW), .CW(16), .DW(DW), .BEATS(BEATS)) i_dma_ctrl4 (
    .clk(clk), .rst_n(rst_n), .dreq_n(dreq_n), .dack_n(dack_n),
    .hold_req(hold_req), .hold_ack(hold_ack), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .bus_addr(bus_addr), .bus_oe(bus_oe),
    .ior_n(ior_n), .iow_n(iow_n), .memr_n(memr_n), .memw_n(memw_n), .tc(tc));

  int checks, bad, cyc, grants, beat;
  logic [15:0] m_addr [NCH];
  logic [15:0] last_addr [NCH];
  int m_cnt [NCH];
  bit m_en [NCH], m_dir [NCH];
  int xfers [NCH];

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor with an independent per-channel model
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; bad++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
    if (mon_on) begin
      ack_echo <= hold_req;
      if (hold_req && !prev_hr) grants++;
      prev_hr = hold_req;
      if (bus_oe) begin
        int ch;
        logic [3:0] exp_s;
        ch = 0;
        for (int i = 0; i < NCH; i++) if (!dack_n[i]) ch = i;
        chk($countones(~dack_n) == 1, "R2 one ack", longint'(dack_n), 0);
        chk(bus_addr == m_addr[ch], "R4 address", bus_addr, m_addr[ch]);
        exp_s = m_dir[ch] ? 4'b1001 : 4'b0110;
        chk({ior_n, iow_n, memr_n, memw_n} == exp_s, "R5 strobes",
            {ior_n, iow_n, memr_n, memw_n}, exp_s);
        beat++;
        if (beat == BEATS) begin
          chk(tc == (m_cnt[ch] == 0), "R6 tc", tc, m_cnt[ch] == 0);
          last_addr[ch] = m_addr[ch];
          if (m_cnt[ch] == 0) m_en[ch] = 1'b0;
          m_addr[ch] = m_addr[ch] + 16'd1;
          m_cnt[ch]  = (m_cnt[ch] == 0) ? 65535 : m_cnt[ch] - 1;
          xfers[ch]++;
          beat = 0;
        end else begin
          chk(tc == 1'b0, "R6 tc early", tc, 0);
        end
      end else begin
        beat = 0;
        chk({ior_n, iow_n, memr_n, memw_n, tc} == 5'b11110, "R5 idle strobes",
            {ior_n, iow_n, memr_n, memw_n, tc}, 5'b11110);
      end
    end
  end

  task automatic wr(int ch, int sel, int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_sel = 2'(sel); cfg_wdata = 16'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // mode: {cascade, mask, single, mem2io, enable}
  task automatic prog(int ch, int addr, int cnt, logic [4:0] mode);
    wr(ch, 0, addr);
    wr(ch, 1, cnt);
    wr(ch, 2, int'(mode));
    m_addr[ch] = 16'(addr);
    m_cnt[ch]  = cnt;
    m_en[ch]   = mode[0];
    m_dir[ch]  = mode[1];
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (!hold_req && !hold_ack) break;
    end
    @(negedge clk);
  endtask

  task automatic wait_dack(int ch);
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (!dack_n[ch]) break;
    end
  endtask

  task automatic wait_done(int ch);
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (!m_en[ch]) break;
    end
  endtask

  initial begin
    int g0, x0;
    int unsigned seed;
    rst_n = 1'b0; dreq_n = '1; cfg_we = 1'b0; cfg_ch = '0; cfg_sel = '0;
    cfg_wdata = '0; auto_ack = 1'b0; man_ack = 1'b0; mon_on = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      m_addr[i] = '0; m_cnt[i] = 0; m_en[i] = 0; m_dir[i] = 0; xfers[i] = 0;
      last_addr[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(!hold_req && &dack_n && !bus_oe && {ior_n, iow_n, memr_n, memw_n} == 4'hF,
        "R12 reset", {hold_req, dack_n, bus_oe}, 6'b011110);
    mon_on = 1'b1;

    // R1: hold handshake, manual grant
    prog(2, 16'h0100, 0, 5'b00101);
    dreq_n[2] = 1'b0;
    repeat (4) @(negedge clk);
    chk(hold_req, "R1 hold_req raised", hold_req, 1);
    chk(&dack_n && !bus_oe, "R1 nothing before ack", {dack_n, bus_oe}, 5'b11110);
    man_ack = 1'b1;
    @(negedge clk);
    chk(dack_n == 4'b1011 && bus_oe, "R1 grant after ack", dack_n, 4'b1011);
    for (int k = 0; k < 20 && hold_req; k++) @(negedge clk);
    chk(&dack_n && !hold_req, "R12 release", dack_n, 4'hF);
    man_ack = 1'b0;
    repeat (4) @(negedge clk);
    chk(!hold_req, "R6 disabled after tc", hold_req, 0);
    chk(xfers[2] == 1, "R6 count 0 gives one byte", xfers[2], 1);
    dreq_n[2] = 1'b1;
    wait_idle();

    // R8: cancel before grant
    prog(1, 16'h0200, 2, 5'b00101);
    dreq_n[1] = 1'b0;
    repeat (3) @(negedge clk);
    chk(hold_req, "R8 waiting", hold_req, 1);
    dreq_n[1] = 1'b1;
    @(negedge clk);
    chk(!hold_req, "R8 hold dropped", hold_req, 0);
    repeat (3) @(negedge clk);
    chk(xfers[1] == 0, "R8 no byte", xfers[1], 0);

    // R3: priority and R7 single-mode re-arbitration
    prog(3, 16'h0300, 0, 5'b00101);
    g0 = grants;
    dreq_n = 4'b0101;
    repeat (3) @(negedge clk);
    man_ack = 1'b1;
    @(negedge clk);
    chk(dack_n == 4'b1101, "R3 channel 1 beats 3", dack_n, 4'b1101);
    auto_ack = 1'b1;
    wait_done(1);
    wait_done(3);
    chk(xfers[1] == 3 && xfers[3] == 1, "R3 both served", xfers[1] * 16 + xfers[3], 8'h31);
    chk(grants - g0 == 4, "R7 single re-arbitrates", grants - g0, 4);
    dreq_n = '1;
    man_ack = 1'b0;
    wait_idle();

    // R9: mask blocks
    prog(0, 16'h0400, 1, 5'b01001);
    dreq_n[0] = 1'b0;
    repeat (6) @(negedge clk);
    chk(!hold_req && xfers[0] == 0, "R9 masked", hold_req, 0);
    dreq_n[0] = 1'b1;
    wait_idle();

    // R10: cascade relays handshake only
    prog(0, 16'h0400, 1, 5'b10000);
    dreq_n[0] = 1'b0;
    wait_dack(0);
    for (int k = 0; k < 5; k++) begin
      chk(dack_n == 4'b1110 && hold_req && !bus_oe, "R10 cascade pass",
          {dack_n, hold_req, bus_oe}, 6'b111010);
      @(negedge clk);
    end
    dreq_n[0] = 1'b1;
    @(negedge clk);
    chk(!hold_req && &dack_n, "R10 cascade release", {hold_req, dack_n}, 5'b01111);
    wait_idle();

    // R7 block mode and R11 write ignored while owning
    prog(2, 16'h0500, 3, 5'b00001);
    prog(3, 16'h0600, 0, 5'b00111);
    g0 = grants;
    x0 = xfers[2];
    dreq_n[2] = 1'b0;
    wait_dack(2);
    wr(3, 0, 16'h1234);
    wait_done(2);
    chk(grants - g0 == 1, "R7 block keeps bus", grants - g0, 1);
    chk(xfers[2] - x0 == 4, "R6 count 3 gives four", xfers[2] - x0, 4);
    dreq_n[2] = 1'b1;
    wait_idle();
    dreq_n[3] = 1'b0;
    wait_done(3);
    chk(last_addr[3] == 16'h0600, "R11 write ignored", last_addr[3], 16'h0600);
    dreq_n[3] = 1'b1;
    wait_idle();

    // Random transfers
    seed = $urandom(32'd4321);
    for (int n = 0; n < 40; n++) begin
      int ch, cnt;
      logic [4:0] md;
      ch  = $urandom_range(0, 3);
      cnt = $urandom_range(0, 4);
      md  = {2'b00, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'b1};
      prog(ch, int'($urandom_range(0, 65535)), cnt, md);
      x0 = xfers[ch];
      dreq_n[ch] = 1'b0;
      wait_done(ch);
      dreq_n[ch] = 1'b1;
      wait_idle();
      chk(xfers[ch] - x0 == cnt + 1, "R6 random byte count", xfers[ch] - x0, cnt + 1);
    end

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule